// File: doc/BRIEF.md
# Position Counter with Snapshot Byte Readout

This block keeps a 32-bit signed-agnostic position count that steps up or down by one on each count pulse from an upstream quadrature decoder. A host reads the count one byte at a time over an 8-bit port. Reading one byte at a time takes several cycles, and the count may change in the meantime. To keep the bytes consistent, the count is copied into a readout latch, and that latch is frozen for as long as a multi-byte read is in progress.

The read controls are an active-low output enable and two byte selects. They are sampled on the falling clock edge. Once the enable is seen low, the latch stops reloading. It starts tracking the counter again only after two things have happened: the least significant byte has been selected with the enable active, and the enable has then been seen high. The output pins are modelled as a data byte plus a drive flag instead of tri-state pads. An asynchronous active-low reset clears the counter, the latch and the freeze state.

Top module: `pos_snap_counter`

## Requirements
- R1: While `rst_n` is low, the counter, the readout latch and the freeze state are cleared asynchronously. A full read after reset, with no pulses, returns 0 in all four bytes.
- R2: On a rising clock edge where `cnt_pulse` is 1, the counter increments by one if `cnt_up` is 1 and decrements by one if `cnt_up` is 0.
- R3: On a rising edge where `cnt_pulse` is 0, the counter holds its value.
- R4: The counter wraps modulo 2^32. Decrementing 0 gives 0xFFFFFFFF, and incrementing 0xFFFFFFFF gives 0.
- R5: The byte selects pick the latch byte as follows, written as {`sel_a`,`sel_b`}:
  - 2'b01 selects bits 31:24.
  - 2'b11 selects bits 23:16.
  - 2'b00 selects bits 15:8.
  - 2'b10 selects bits 7:0, the least significant byte.
- R6: `dout_en` equals the inverse of `oe_n`. While `oe_n` is 1, `dout` is 0.
- R7: While the latch is not frozen and `oe_n` is sampled high, the latch reloads from the counter on every falling clock edge.
- R8: A falling edge that samples `oe_n` low freezes the latch and does not load it. The counter keeps counting while the latch is frozen.
- R9: The latch stays frozen until the least significant byte has been selected while `oe_n` is sampled low, and `oe_n` is then sampled high on a later falling edge. Raising `oe_n` before that point does not unfreeze the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on the rising edge, the read controls are sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pulse | input | 1 | One-cycle count request from the decoder |
| cnt_up | input | 1 | Direction: 1 counts up, 0 counts down |
| oe_n | input | 1 | Active-low output enable; also starts a frozen read |
| sel_a | input | 1 | Byte select, first bit |
| sel_b | input | 1 | Byte select, second bit |
| dout | output | 8 | Selected latch byte; 0 when not driven |
| dout_en | output | 1 | Drive flag standing in for the tri-state buffer enable |

## Verification
A counter that steps wrongly shows up as a wrong byte on the first full read that follows. That read starts two idle cycles after the pulses stop, so the error is visible within a few cycles. A freeze that fails to take hold, or releases too early, shows a different kind of error: the bytes of one read mix two values, because pulses keep arriving while the read is in progress. A freeze that never releases shows up differently again: the next read, after further counting, returns the old snapshot. The sweep drives a pseudo-random series of up and down pulse bursts around the wrap point. It compares every byte against a count kept arithmetically in the bench.

// File: rtl/pos_snap_counter.sv
module pos_snap_counter #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_pulse,
  input  logic              cnt_up,
  input  logic              oe_n,
  input  logic              sel_a,
  input  logic              sel_b,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count, snap;
  logic             frozen, lsb_done;
  logic [1:0]       bidx;
  logic             lsb_pick;

  assign bidx     = {sel_b, ~sel_a};
  assign lsb_pick = sel_a & ~sel_b;
  assign dout_en  = ~oe_n;
  assign dout     = oe_n ? '0 : snap[int'(bidx)*BYTE_W +: BYTE_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          count <= '0;
    else if (cnt_pulse)  count <= cnt_up ? count + ONE : count - ONE;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      snap     <= '0;
      frozen   <= 1'b0;
      lsb_done <= 1'b0;
    end else begin
      if (!frozen && oe_n) snap <= count;
      if (!oe_n) begin
        frozen <= 1'b1;
        if (lsb_pick) lsb_done <= 1'b1;
      end else if (lsb_done) begin
        frozen   <= 1'b0;
        lsb_done <= 1'b0;
      end
    end

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse && cnt_up |=> count == $past(count) + ONE);
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse && !cnt_up |=> count == $past(count) - ONE);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(count));
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dout == '0) && !dout_en);
  a_r8_freeze_on_read: assert property (@(negedge clk) disable iff (!rst_n)
    !oe_n |=> frozen);
  a_r8_latch_stable: assert property (@(negedge clk) disable iff (!rst_n)
    frozen |=> $stable(snap));
  a_r9_no_early_release: assert property (@(negedge clk) disable iff (!rst_n)
    frozen && oe_n && !lsb_done |=> frozen);
endmodule

// File: tb/pos_snap_counter_tb.sv
module pos_snap_counter_tb_top;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, cnt_pulse = 0, cnt_up = 0, oe_n = 1, sel_a = 0, sel_b = 0;
  logic [7:0] dout;
  logic dout_en;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  pos_snap_counter dut_i (.clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
    .oe_n(oe_n), .sel_a(sel_a), .sel_b(sel_b), .dout(dout), .dout_en(dout_en));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic drive(input logic p, input logic d, input logic o, input logic sa, input logic sb);
    @(posedge clk); #2;
    cnt_pulse = p; cnt_up = d; oe_n = o; sel_a = sa; sel_b = sb;
    if (p) exp_cnt = d ? exp_cnt + 1 : exp_cnt - 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 1, 0, 0);
  endtask

  task automatic pulses(input int n, input logic d);
    for (int i = 0; i < n; i++) drive(1, d, 1, 0, 0);
  endtask

  function automatic logic nxt();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // R5 select codes: byte 3 -> 01, byte 2 -> 11, byte 1 -> 00, byte 0 -> 10
  task automatic read_byte(input int k, input logic p, input logic d, input logic [31:0] snapv, input string req);
    drive(p, d, 0, (k == 2 || k == 0), (k >= 2));
    #6;
    chk(req, {24'b0, dout}, {24'b0, snapv[k*8 +: 8]});
    chk("R6 drive flag on", {31'b0, dout_en}, 32'd1);
  endtask

  task automatic read_all(input logic [31:0] snapv, input logic busy, input string req);
    for (int k = 3; k >= 0; k--) read_byte(k, busy, nxt(), snapv, req);
    drive(busy, nxt(), 1, 0, 0);
  endtask

  initial begin
    logic [31:0] s;
    #3;
    chk("R6 reset bus quiet", {23'b0, dout_en, dout}, 32'd0);
    #20 rst_n = 1;
    idle(2);
    read_all(32'd0, 0, "R1 R5 read after reset");
    pulses(5, 1); idle(2);
    read_all(exp_cnt, 0, "R2 R7 count up");
    #6 chk("R6 disabled bus", {23'b0, dout_en, dout}, 32'd0);
    pulses(7, 0); idle(2);
    read_all(32'hFFFF_FFFE, 0, "R4 wrap down");
    pulses(2, 1); idle(2);
    read_all(32'd0, 0, "R4 wrap up");
    pulses(1, 0); idle(5);
    read_all(32'hFFFF_FFFF, 0, "R3 hold while idle");
    pulses(300, 1); idle(2);
    s = exp_cnt;
    read_all(s, 1, "R8 frozen while counting");
    idle(2);
    read_all(exp_cnt, 0, "R8 counting continued");
    pulses(3, 1); idle(2);
    s = exp_cnt;
    read_byte(3, 1, 1, s, "R9 partial read");
    pulses(4, 1); idle(2);
    read_all(s, 0, "R9 still frozen");
    idle(2);
    read_all(exp_cnt, 0, "R9 released");
    pulses(9, 1);
    drive(0, 0, 0, 0, 1);
    @(posedge clk); #2 rst_n = 0; oe_n = 1; exp_cnt = 0;
    #10 rst_n = 1;
    idle(2);
    read_all(32'd0, 0, "R1 reset mid read");
    for (int r = 0; r < 40; r++) begin
      int n;
      n = {nxt(), nxt(), nxt(), nxt()};
      for (int i = 0; i < n; i++) drive(1, nxt(), 1, 0, 0);
      idle(2);
      read_all(exp_cnt, 1, "R2 R4 R8 sweep");
    end
    idle(2);
    read_all(exp_cnt, 0, "R2 sweep final");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule